// File: doc/BRIEF.md
# ALU Q-register and output shifter

This block is the arithmetic slice of a microcoded processor's datapath. It combines two 32-bit operands into one result and keeps a 32-bit Q register next to the ALU. The result drives an output bus, either unchanged or shifted one place in either direction. Fields of the current microinstruction choose all of this: the ALU function and mode, a carry-in bit, a two-bit Q control and a two-bit output select. The adder forms its carries with lookahead over 4-bit groups, so carries enter the groups at bits 4, 8, ..., 28 and leave at bit 32.

The Q register takes its shift-in bits from the ALU result. A left shift fills bit 0 with the inverted ALU sign. A right shift fills bit 31 with ALU bit 0. The output left shift fills bit 0 with Q bit 31. With these paths, a two-bit step field can run one iteration per cycle of shift-and-add multiply and of non-restoring divide. In a multiply step, Q bit 0 chooses between add and pass. In a divide step, a one-bit record of the previous partial-remainder sign chooses between add and subtract. In both step kinds the block overrides the function, mode and carry-in fields.

Top module: `alu_qshift`

## Requirements
- R1: With `step_sel`=0 and `alu_mode`=0 (arithmetic), `alu_res` = `op_a` + Y + `carry_in` modulo 2^32. Y is chosen by `alu_fn[1:0]`: 0 gives `op_b`, 1 gives ~`op_b`, 2 gives zero, 3 gives all ones. `alu_fn[3:2]` has no effect. `alu_cout` is the carry out of bit 31.
- R2: With `step_sel`=0 and `alu_mode`=1 (logic), result bit i equals `alu_fn[2*op_a[i] + op_b[i]]`. In this mode `alu_cout` is 0 and `carry_in` has no effect.
- R3: A carry travels across every 4-bit group boundary. For example, all ones + 0 + carry-in 1 gives 0 with `alu_cout`=1.
- R4: Q is unchanged when `alu_valid`=0, and also when `q_ctl`=0.
- R5: With `alu_valid`=1 and `q_ctl`=1, the next Q is {Q[30:0], ~`alu_res[31]`}.
- R6: With `alu_valid`=1 and `q_ctl`=2, the next Q is {`alu_res[0]`, Q[31:1]}.
- R7: With `alu_valid`=1 and `q_ctl`=3, the next Q is `alu_res`.
- R8: `out_sel`=0 drives zero onto `bus_out`. `out_sel`=1 drives `alu_res`.
- R9: `out_sel`=2 drives {S, `alu_res[31:1]`}. S is the true sign: `alu_res[31]` XOR signed overflow, where overflow is 0 in logic mode.
- R10: `out_sel`=3 drives {`alu_res[30:0]`, Q[31]}, using the Q value held before the clock edge.
- R11: `step_sel`=1 (multiply step) computes `op_a`+`op_b` when Q[0]=1 and `op_a` when Q[0]=0, with carry 0. `alu_fn`, `alu_mode` and `carry_in` are ignored.
- R12: `step_sel`=3 (first divide step) computes `op_a`-`op_b`. `step_sel`=2 computes `op_a`+`op_b` if the recorded sign is negative and `op_a`-`op_b` otherwise. Both step kinds record the true sign of their result on a valid cycle.
- R13: Synchronous reset clears Q to zero and sets the recorded divide sign to non-negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_valid | input | 1 | An ALU-type microinstruction is active this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| alu_fn | input | 4 | ALU function / logic truth table |
| alu_mode | input | 1 | 1 = logic, 0 = arithmetic |
| carry_in | input | 1 | Carry into bit 0 |
| q_ctl | input | 2 | Q update: hold, shift left, shift right, load |
| out_sel | input | 2 | Bus: zero, pass, shift right, shift left |
| step_sel | input | 2 | none, multiply step, divide step, first divide step |
| alu_res | output | 32 | ALU result |
| alu_cout | output | 1 | Carry out of bit 31 |
| bus_out | output | 32 | Output bus |
| q_out | output | 32 | Q register |

## Verification
The Q update and the output left shift can act in the same cycle. Both read Q: the bus must use the old Q[31] while the clock edge writes the shifted Q. The bench provokes this by driving `out_sel`=3 together with `q_ctl`=1, and by running a multiply step that tests Q[0] together with a Q right shift. It judges the bus before the edge against the bench's own Q model, and judges Q after the edge against the updated model. The step tests also cover the recorded divide sign, which is written in the same cycle that it steers.

// File: rtl/alu_qs_pkg.sv
package alu_qs_pkg;

    typedef enum logic [1:0] {
        QC_HOLD = 2'd0,
        QC_SHL  = 2'd1,
        QC_SHR  = 2'd2,
        QC_LOAD = 2'd3
    } qctl_e;

    typedef enum logic [1:0] {
        OS_ZERO = 2'd0,
        OS_PASS = 2'd1,
        OS_SHR  = 2'd2,
        OS_SHL  = 2'd3
    } osel_e;

    typedef enum logic [1:0] {
        ST_NONE      = 2'd0,
        ST_MUL       = 2'd1,
        ST_DIV       = 2'd2,
        ST_DIV_FIRST = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        Y_B    = 2'd0,
        Y_NB   = 2'd1,
        Y_ZERO = 2'd2,
        Y_ONES = 2'd3
    } ysel_e;

    typedef struct packed {
        logic       logic_mode;
        logic [3:0] tt;
        ysel_e      ysel;
        logic       cin;
    } alu_ctl_t;

    function automatic logic tt_pick(input logic [3:0] tt, input logic a, input logic b);
        return tt[{a, b}];
    endfunction

endpackage

// File: rtl/alu_qs_ctl.sv
module alu_qs_ctl
    import alu_qs_pkg::*;
(
    input  logic [3:0] alu_fn,
    input  logic       alu_mode,
    input  logic       carry_in,
    input  step_e      step,
    input  logic       q_lsb,
    input  logic       prev_neg,
    output alu_ctl_t   ctl
);

    always_comb begin
        ctl.logic_mode = alu_mode;
        ctl.tt         = alu_fn;
        ctl.ysel       = ysel_e'(alu_fn[1:0]);
        ctl.cin        = carry_in;
        case (step)
            ST_MUL: begin
                ctl.logic_mode = 1'b0;
                ctl.ysel       = q_lsb ? Y_B : Y_ZERO;
                ctl.cin        = 1'b0;
            end
            ST_DIV: begin
                ctl.logic_mode = 1'b0;
                ctl.ysel       = prev_neg ? Y_B : Y_NB;
                ctl.cin        = ~prev_neg;
            end
            ST_DIV_FIRST: begin
                ctl.logic_mode = 1'b0;
                ctl.ysel       = Y_NB;
                ctl.cin        = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu_qs_cla.sv
module alu_qs_cla #(
    parameter int W  = 32,
    parameter int GW = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    localparam int NG = W / GW;

    logic [W-1:0]  bit_g;
    logic [W-1:0]  bit_p;
    logic [NG-1:0] grp_g;
    logic [NG-1:0] grp_p;
    logic [NG:0]   grp_c;
    logic [W:0]    bit_c;

    assign bit_g = x & y;
    assign bit_p = x ^ y;

    // group generate/propagate and in-group carries
    for (genvar k = 0; k < NG; k++) begin : g_grp
        logic          g_l;
        logic          p_l;
        logic [GW:0]   lc;
        always_comb begin
            g_l = 1'b0;
            p_l = 1'b1;
            for (int i = 0; i < GW; i++) begin
                g_l = bit_g[k*GW+i] | (bit_p[k*GW+i] & g_l);
                p_l = p_l & bit_p[k*GW+i];
            end
        end
        always_comb begin
            lc[0] = grp_c[k];
            for (int i = 0; i < GW; i++) begin
                lc[i+1] = bit_g[k*GW+i] | (bit_p[k*GW+i] & lc[i]);
            end
        end
        assign grp_g[k]             = g_l;
        assign grp_p[k]             = p_l;
        assign bit_c[k*GW +: GW]    = lc[GW-1:0];
    end

    // second level: each group carry-in as a flat sum of products
    always_comb begin
        logic acc;
        logic prod;
        grp_c[0] = cin;
        for (int k = 1; k <= NG; k++) begin
            acc = cin;
            for (int j = 0; j < k; j++) acc = acc & grp_p[j];
            for (int j = 0; j < k; j++) begin
                prod = grp_g[j];
                for (int m = j + 1; m < k; m++) prod = prod & grp_p[m];
                acc = acc | prod;
            end
            grp_c[k] = acc;
        end
    end

    assign bit_c[W] = grp_c[NG];
    assign sum      = bit_p ^ bit_c[W-1:0];
    assign cout     = bit_c[W];
    assign ovf      = bit_c[W] ^ bit_c[W-1];

endmodule

// File: rtl/alu_qs_core.sv
module alu_qs_core
    import alu_qs_pkg::*;
#(
    parameter int W  = 32,
    parameter int GW = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_ctl_t     ctl,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         ovf
);

    logic [W-1:0] y_op;
    logic [W-1:0] sum;
    logic [W-1:0] lres;
    logic         add_c;
    logic         add_v;

    always_comb begin
        case (ctl.ysel)
            Y_B:     y_op = b;
            Y_NB:    y_op = ~b;
            Y_ZERO:  y_op = '0;
            default: y_op = '1;
        endcase
    end

    alu_qs_cla #(.W(W), .GW(GW)) u_cla (
        .x    (a),
        .y    (y_op),
        .cin  (ctl.cin),
        .sum  (sum),
        .cout (add_c),
        .ovf  (add_v)
    );

    for (genvar i = 0; i < W; i++) begin : g_lbit
        assign lres[i] = tt_pick(ctl.tt, a[i], b[i]);
    end

    assign res  = ctl.logic_mode ? lres : sum;
    assign cout = ~ctl.logic_mode & add_c;
    assign ovf  = ~ctl.logic_mode & add_v;

endmodule

// File: rtl/alu_qs_qreg.sv
module alu_qs_qreg
    import alu_qs_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  qctl_e        qctl,
    input  logic [W-1:0] res,
    input  logic         sign_now,
    input  logic         div_upd,
    output logic [W-1:0] q,
    output logic         prev_neg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            prev_neg <= 1'b0;
        end else if (en) begin
            case (qctl)
                QC_SHL:  q <= {q[W-2:0], ~res[W-1]};
                QC_SHR:  q <= {res[0], q[W-1:1]};
                QC_LOAD: q <= res;
                default: ;
            endcase
            if (div_upd) prev_neg <= sign_now;
        end
    end

endmodule

// File: rtl/alu_qs_outmux.sv
module alu_qs_outmux
    import alu_qs_pkg::*;
#(
    parameter int W = 32
) (
    input  osel_e        sel,
    input  logic [W-1:0] res,
    input  logic         true_sign,
    input  logic         q_msb,
    output logic [W-1:0] bus
);

    always_comb begin
        case (sel)
            OS_PASS: bus = res;
            OS_SHR:  bus = {true_sign, res[W-1:1]};
            OS_SHL:  bus = {res[W-2:0], q_msb};
            default: bus = '0;
        endcase
    end

endmodule

// File: rtl/alu_qshift.sv
module alu_qshift
    import alu_qs_pkg::*;
#(
    parameter int W  = 32,
    parameter int GW = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         alu_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   alu_fn,
    input  logic         alu_mode,
    input  logic         carry_in,
    input  logic [1:0]   q_ctl,
    input  logic [1:0]   out_sel,
    input  logic [1:0]   step_sel,
    output logic [W-1:0] alu_res,
    output logic         alu_cout,
    output logic [W-1:0] bus_out,
    output logic [W-1:0] q_out
);

    alu_ctl_t     ctl;
    logic         prev_neg;
    logic         ovf;
    logic         true_sign;
    step_e        step;

    assign step      = step_e'(step_sel);
    assign true_sign = alu_res[W-1] ^ ovf;

    alu_qs_ctl u_ctl (
        .alu_fn   (alu_fn),
        .alu_mode (alu_mode),
        .carry_in (carry_in),
        .step     (step),
        .q_lsb    (q_out[0]),
        .prev_neg (prev_neg),
        .ctl      (ctl)
    );

    alu_qs_core #(.W(W), .GW(GW)) u_core (
        .a    (op_a),
        .b    (op_b),
        .ctl  (ctl),
        .res  (alu_res),
        .cout (alu_cout),
        .ovf  (ovf)
    );

    alu_qs_qreg #(.W(W)) u_qreg (
        .clk      (clk),
        .rst      (rst),
        .en       (alu_valid),
        .qctl     (qctl_e'(q_ctl)),
        .res      (alu_res),
        .sign_now (true_sign),
        .div_upd  (step_sel[1]),
        .q        (q_out),
        .prev_neg (prev_neg)
    );

    alu_qs_outmux #(.W(W)) u_out (
        .sel       (osel_e'(out_sel)),
        .res       (alu_res),
        .true_sign (true_sign),
        .q_msb     (q_out[W-1]),
        .bus       (bus_out)
    );

endmodule

// File: rtl/alu_qshift_chk.sv
module alu_qshift_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         alu_valid,
    input logic         alu_mode,
    input logic [1:0]   q_ctl,
    input logic [1:0]   out_sel,
    input logic [1:0]   step_sel,
    input logic [W-1:0] alu_res,
    input logic         alu_cout,
    input logic [W-1:0] bus_out,
    input logic [W-1:0] q_out
);

    assert_q_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!alu_valid || q_ctl == 2'd0) |=> q_out == $past(q_out));

    assert_q_shl_R5: assert property (@(posedge clk) disable iff (rst)
        (alu_valid && q_ctl == 2'd1) |=> q_out == {$past(q_out[W-2:0]), ~$past(alu_res[W-1])});

    assert_q_shr_R6: assert property (@(posedge clk) disable iff (rst)
        (alu_valid && q_ctl == 2'd2) |=> q_out == {$past(alu_res[0]), $past(q_out[W-1:1])});

    assert_q_load_R7: assert property (@(posedge clk) disable iff (rst)
        (alu_valid && q_ctl == 2'd3) |=> q_out == $past(alu_res));

    assert_bus_zero_R8: assert property (@(posedge clk) disable iff (rst)
        out_sel == 2'd0 |-> bus_out == '0);

    assert_bus_shr_R9: assert property (@(posedge clk) disable iff (rst)
        out_sel == 2'd2 |-> bus_out[W-2:0] == alu_res[W-1:1]);

    assert_bus_shl_R10: assert property (@(posedge clk) disable iff (rst)
        out_sel == 2'd3 |-> bus_out == {alu_res[W-2:0], q_out[W-1]});

    assert_logic_cout_R2: assert property (@(posedge clk) disable iff (rst)
        (step_sel == 2'd0 && alu_mode) |-> !alu_cout);

endmodule

bind alu_qshift alu_qshift_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .alu_valid (alu_valid),
    .alu_mode  (alu_mode),
    .q_ctl     (q_ctl),
    .out_sel   (out_sel),
    .step_sel  (step_sel),
    .alu_res   (alu_res),
    .alu_cout  (alu_cout),
    .bus_out   (bus_out),
    .q_out     (q_out)
);

// File: tb/alu_qshift_test.sv
module alu_qshift_test;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         alu_valid;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic [3:0]   alu_fn;
    logic         alu_mode;
    logic         carry_in;
    logic [1:0]   q_ctl;
    logic [1:0]   out_sel;
    logic [1:0]   step_sel;
    logic [W-1:0] alu_res;
    logic         alu_cout;
    logic [W-1:0] bus_out;
    logic [W-1:0] q_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] qm;
    logic         pm;

    always #4 clk = ~clk;

    alu_qshift uut (
        .clk(clk), .rst(rst), .alu_valid(alu_valid), .op_a(op_a), .op_b(op_b),
        .alu_fn(alu_fn), .alu_mode(alu_mode), .carry_in(carry_in), .q_ctl(q_ctl),
        .out_sel(out_sel), .step_sel(step_sel), .alu_res(alu_res),
        .alu_cout(alu_cout), .bus_out(bus_out), .q_out(q_out)
    );

    task automatic chk(input string tag, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // drive one cycle at a falling edge, check combinational outputs,
    // then the Q register after the rising edge
    task automatic apply(input string tag, input logic v,
                         input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [3:0] fn, input logic md, input logic ci,
                         input logic [1:0] qc, input logic [1:0] os, input logic [1:0] st);
        logic [W-1:0] y, r, bx;
        logic [W:0]   s;
        logic         c, lm, co, ov, ts;
        alu_valid = v; op_a = a; op_b = b; alu_fn = fn; alu_mode = md;
        carry_in = ci; q_ctl = qc; out_sel = os; step_sel = st;
        #1;
        lm = md; c = ci;
        case (fn[1:0])
            2'd0: y = b;
            2'd1: y = ~b;
            2'd2: y = '0;
            default: y = '1;
        endcase
        case (st)
            2'd1: begin lm = 1'b0; y = qm[0] ? b : '0; c = 1'b0; end
            2'd2: begin lm = 1'b0; y = pm ? b : ~b; c = ~pm; end
            2'd3: begin lm = 1'b0; y = ~b; c = 1'b1; end
            default: ;
        endcase
        if (lm) begin
            for (int i = 0; i < W; i++) r[i] = fn[{a[i], b[i]}];
            co = 1'b0; ov = 1'b0;
        end else begin
            s  = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, c};
            r  = s[W-1:0];
            co = s[W];
            ov = (a[W-1] == y[W-1]) && (r[W-1] != a[W-1]);
        end
        ts = r[W-1] ^ ov;
        case (os)
            2'd0: bx = '0;
            2'd1: bx = r;
            2'd2: bx = {ts, r[W-1:1]};
            default: bx = {r[W-2:0], qm[W-1]};
        endcase
        chk(tag, "alu_res", alu_res, r);
        chk(tag, "alu_cout", {31'b0, alu_cout}, {31'b0, co});
        chk(tag, "bus_out", bus_out, bx);
        @(posedge clk);
        if (v) begin
            case (qc)
                2'd1: qm = {qm[W-2:0], ~r[W-1]};
                2'd2: qm = {r[0], qm[W-1:1]};
                2'd3: qm = r;
                default: ;
            endcase
            if (st[1]) pm = ts;
        end
        @(negedge clk);
        chk(tag, "q_out", q_out, qm);
    endtask

    task automatic t_reset;
        chk("R13", "q after reset", q_out, '0);
        // recorded sign must start non-negative: a plain divide step subtracts
        apply("R13", 1, 32'd10, 32'd3, 4'h0, 1'b0, 1'b0, 2'd0, 2'd1, 2'd2);
        apply("R8",  1, 32'hDEAD_BEEF, 32'h1, 4'h0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0);
    endtask

    task automatic t_arith;
        apply("R1", 1, 32'h1234_5678, 32'h0F0F_0F0F, 4'h0, 1'b0, 1'b0, 2'd0, 2'd1, 2'd0);
        apply("R1", 1, 32'd100, 32'd58, 4'h1, 1'b0, 1'b1, 2'd0, 2'd1, 2'd0);
        apply("R1", 1, 32'd100, 32'd58, 4'hD, 1'b0, 1'b1, 2'd0, 2'd1, 2'd0);
        apply("R1", 1, 32'hABCD_0000, 32'h5555_5555, 4'h2, 1'b0, 1'b1, 2'd0, 2'd1, 2'd0);
        apply("R1", 1, 32'h0000_0000, 32'h0, 4'h3, 1'b0, 1'b0, 2'd0, 2'd1, 2'd0);
    endtask

    task automatic t_carry;
        apply("R3", 1, 32'hFFFF_FFFF, 32'h0, 4'h2, 1'b0, 1'b1, 2'd0, 2'd1, 2'd0);
        apply("R3", 1, 32'h0000_0FFF, 32'h1, 4'h0, 1'b0, 1'b0, 2'd0, 2'd1, 2'd0);
        apply("R3", 1, 32'h0FFF_FFFF, 32'h1, 4'h0, 1'b0, 1'b1, 2'd0, 2'd1, 2'd0);
        apply("R3", 1, 32'hF0F0_F0F0, 32'h0F0F_0F10, 4'h0, 1'b0, 1'b0, 2'd0, 2'd1, 2'd0);
    endtask

    task automatic t_logic;
        apply("R2", 1, 32'hFF00_F0F0, 32'hF0F0_FF00, 4'h8, 1'b1, 1'b1, 2'd0, 2'd1, 2'd0);
        apply("R2", 1, 32'hFF00_F0F0, 32'hF0F0_FF00, 4'hE, 1'b1, 1'b0, 2'd0, 2'd1, 2'd0);
        apply("R2", 1, 32'hFF00_F0F0, 32'hF0F0_FF00, 4'h6, 1'b1, 1'b1, 2'd0, 2'd1, 2'd0);
        apply("R2", 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'h3, 1'b1, 1'b1, 2'd0, 2'd1, 2'd0);
    endtask

    task automatic t_bus_shr;
        apply("R9", 1, 32'h7FFF_FFFF, 32'h1, 4'h0, 1'b0, 1'b0, 2'd0, 2'd2, 2'd0);
        apply("R9", 1, 32'h8000_0000, 32'hFFFF_FFFF, 4'h0, 1'b0, 1'b0, 2'd0, 2'd2, 2'd0);
        apply("R9", 1, 32'hFFFF_FFF0, 32'h0, 4'h0, 1'b0, 1'b0, 2'd0, 2'd2, 2'd0);
        apply("R9", 1, 32'h8000_0001, 32'h0, 4'hC, 1'b1, 1'b0, 2'd0, 2'd2, 2'd0);
    endtask

    task automatic t_qreg;
        apply("R7", 1, 32'h8000_0001, 32'h0, 4'h2, 1'b0, 1'b0, 2'd3, 2'd1, 2'd0);
        apply("R5", 1, 32'h8000_0000, 32'h0, 4'h2, 1'b0, 1'b0, 2'd1, 2'd1, 2'd0);
        apply("R5", 1, 32'h0000_0000, 32'h0, 4'h2, 1'b0, 1'b0, 2'd1, 2'd1, 2'd0);
        apply("R6", 1, 32'h0000_0001, 32'h0, 4'h2, 1'b0, 1'b0, 2'd2, 2'd1, 2'd0);
        apply("R6", 1, 32'h0000_0002, 32'h0, 4'h2, 1'b0, 1'b0, 2'd2, 2'd1, 2'd0);
        apply("R4", 1, 32'h1357_9BDF, 32'h0, 4'h2, 1'b0, 1'b0, 2'd0, 2'd1, 2'd0);
        apply("R4", 0, 32'h2468_ACE0, 32'h0, 4'h2, 1'b0, 1'b0, 2'd3, 2'd1, 2'd0);
        apply("R4", 0, 32'h2468_ACE0, 32'h0, 4'h2, 1'b0, 1'b0, 2'd1, 2'd1, 2'd0);
    endtask

    task automatic t_bus;
        apply("R8",  1, 32'h0000_00FF, 32'h0, 4'h2, 1'b0, 1'b0, 2'd3, 2'd0, 2'd0);
        apply("R8",  1, 32'h0000_00FF, 32'h0, 4'h2, 1'b0, 1'b0, 2'd0, 2'd1, 2'd0);
        apply("R10", 1, 32'hC000_0001, 32'h0, 4'h2, 1'b0, 1'b0, 2'd0, 2'd3, 2'd0);
        apply("R10", 1, 32'h8000_0000, 32'h0, 4'h2, 1'b0, 1'b0, 2'd3, 2'd1, 2'd0);
        apply("R10", 1, 32'h4000_0001, 32'h0, 4'h2, 1'b0, 1'b0, 2'd0, 2'd3, 2'd0);
    endtask

    // Q update and the bus read of Q in one cycle
    task automatic t_overlap;
        apply("R10", 1, 32'h0000_0003, 32'h0, 4'h2, 1'b0, 1'b0, 2'd1, 2'd3, 2'd0);
        apply("R5",  1, 32'h7000_0000, 32'h0, 4'h2, 1'b0, 1'b0, 2'd1, 2'd3, 2'd0);
    endtask

    task automatic t_mul;
        apply("R11", 1, 32'd5, 32'h0, 4'h2, 1'b0, 1'b0, 2'd3, 2'd1, 2'd0);
        apply("R11", 1, 32'd100, 32'd7, 4'hF, 1'b1, 1'b1, 2'd2, 2'd1, 2'd1);
        apply("R11", 1, 32'd100, 32'd7, 4'h5, 1'b0, 1'b1, 2'd2, 2'd1, 2'd1);
        apply("R11", 1, 32'hFFFF_FFFF, 32'd1, 4'h8, 1'b1, 1'b0, 2'd0, 2'd3, 2'd1);
    endtask

    task automatic t_div;
        apply("R12", 1, 32'd10, 32'd3, 4'hA, 1'b1, 1'b0, 2'd0, 2'd1, 2'd3);
        apply("R12", 1, 32'd2, 32'd5, 4'h0, 1'b0, 1'b1, 2'd0, 2'd2, 2'd2);
        apply("R12", 1, 32'd4, 32'd5, 4'h0, 1'b1, 1'b0, 2'd1, 2'd1, 2'd2);
        apply("R12", 1, 32'd20, 32'd5, 4'h0, 1'b0, 1'b0, 2'd0, 2'd1, 2'd2);
        apply("R12", 0, 32'h8000_0000, 32'd1, 4'h0, 1'b0, 1'b0, 2'd0, 2'd1, 2'd3);
        apply("R12", 1, 32'd9, 32'd4, 4'h0, 1'b0, 1'b0, 2'd0, 2'd1, 2'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; alu_valid = 1'b0; op_a = '0; op_b = '0; alu_fn = '0;
        alu_mode = 1'b0; carry_in = 1'b0; q_ctl = '0; out_sel = '0; step_sel = '0;
        qm = '0; pm = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_arith;
        t_carry;
        t_logic;
        t_bus_shr;
        t_qreg;
        t_bus;
        t_overlap;
        t_mul;
        t_div;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule